// File: doc/BRIEF.md
# DMA Completion Response Port

This block holds the completion records of a scatter-gather DMA engine until software collects them. Each time the descriptor dispatcher finishes a descriptor, it pushes one record into a small FIFO. The record holds the number of bytes moved, an 8-bit error code and a flag that marks early termination. The dispatcher sees backpressure through a valid/ready pair, so no record is ever dropped.

Software collects a record through a two-word read window. Offset 0x0 returns the byte count of the oldest record and leaves the FIFO as it is. Offset 0x4 returns the status word and, as a side effect of that read, removes the record. The FIFO occupancy is exported as a CSR-ready word with the count in bits 15:0, together with separate empty and full flags. Read data is registered and appears one cycle after the read strobe, qualified by `rd_valid`.

Occupancy is tracked by a three-state machine:
- ST_EMPTY holds no record. T_FILL_FIRST leaves it on a push.
- ST_PARTIAL holds between one and DEPTH-1 records. T_TOP_OFF moves to ST_FULL when a push alone reaches DEPTH. T_DRAIN_LAST moves to ST_EMPTY when a pop alone removes the last record. T_EXCHANGE stays put when a push and a pop land together.
- ST_FULL holds DEPTH records and refuses pushes. T_RELEASE leaves it on a pop.

The depth is a parameter and defaults to 16.

Top module: `dma_resp_port`

## Requirements
- R1: After reset the port shows `empty_o`=1, `full_o`=0, `fill_word`=0, `push_ready`=1 and `rd_valid`=0.
- R2: A read strobe at offset 0x0 returns, one cycle later with `rd_valid`=1, the 32-bit byte count of the oldest record. It does not change the occupancy.
- R3: A read strobe at offset 0x4 returns, one cycle later, the status word: bits 7:0 hold the error code, bit 8 holds the early-termination flag and bits 31:9 are zero. The same read removes the record, so `fill_word` drops by one on the next cycle.
- R4: Records leave in the order they were pushed, including after the storage pointers wrap past DEPTH.
- R5: A read of any offset while the FIFO is empty returns zero and leaves `fill_word` at zero. A following push and read behave normally.
- R6: While DEPTH records are held, `full_o`=1 and `push_ready`=0. A push held valid during that time is not taken and is not lost; occupancy never exceeds DEPTH.
- R7: Bits 15:0 of `fill_word` carry the record count and bits 31:16 are zero. `empty_o` is 1 exactly when the count is 0, and `full_o` is 1 exactly when it equals DEPTH.
- R8: A push and a status read in the same cycle on a non-empty FIFO leave the count unchanged. The read returns the old head and the new record is appended at the tail.
- R9: Reads at offsets 0x1, 0x2, 0x3, 0x5, 0x6 and 0x7 return zero and remove nothing.
- R10: A status read while full frees a slot, so `push_ready` is 1 in the next cycle and a waiting push is taken on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Dispatcher offers a completion record |
| push_ready | output | 1 | Record is taken on this edge when push_valid is also 1 |
| push_bytes | input | 32 | Bytes moved by the finished descriptor |
| push_err | input | 8 | Error code of the finished descriptor |
| push_early | input | 1 | Descriptor ended early |
| rd_en | input | 1 | Read strobe from the register bus |
| rd_addr | input | 3 | Byte offset within the read window |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | rd_data holds the result of the previous strobe |
| fill_word | output | 32 | CSR word with the record count in bits 15:0 |
| empty_o | output | 1 | No record held |
| full_o | output | 1 | DEPTH records held |

## Verification
Two functions can land in the same cycle: a dispatcher push and a software status read that pops. The bench provokes this with both strobes driven on one edge. It does so with records already present, where the count must stay put, the read must return the old head, and a later drain must show the new record at the tail. It also does so on an empty FIFO, where the read must return zero and the count must become one. A second overlap is a push held against a full FIFO while a status read releases a slot. There the bench judges that the held record is taken exactly one edge after the pop and that it comes out last.

// File: rtl/dma_resp_pkg.sv
package dma_resp_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTES_W = 32;
    localparam int ERR_W   = 8;
    localparam int OFS_W   = 3;
    localparam int LVL_W   = 16;

    localparam logic [OFS_W-1:0] OFS_BYTES  = 3'h0;
    localparam logic [OFS_W-1:0] OFS_STATUS = 3'h4;

    typedef struct packed {
        logic               early;
        logic [ERR_W-1:0]   err;
        logic [BYTES_W-1:0] bytes;
    } resp_rec_t;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_e;

    function automatic logic [WORD_W-1:0] status_word(input resp_rec_t r);
        logic [WORD_W-1:0] w;
        w = '0;
        w[ERR_W-1:0] = r.err;
        w[ERR_W]     = r.early;
        return w;
    endfunction

endpackage

// File: rtl/resp_store.sv
module resp_store
    import dma_resp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  resp_rec_t wr_rec,
    input  logic      rd_adv,
    output resp_rec_t head_rec
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    resp_rec_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (rd_adv) begin
                rd_ptr <= bump(rd_ptr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_rec;
        end
    end

    assign head_rec = mem[rd_ptr];

endmodule

// File: rtl/resp_occ_fsm.sv
module resp_occ_fsm
    import dma_resp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [CNT_W-1:0] count,
    output logic             is_empty,
    output logic             is_full
);

    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    occ_state_e       state;
    occ_state_e       state_nx;
    logic [CNT_W-1:0] count_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            count <= '0;
        end else begin
            state <= state_nx;
            count <= count_nx;
        end
    end

    // next state: transitions named as in the brief
    always_comb begin
        state_nx = state;
        count_nx = count;
        unique case (state)
            ST_EMPTY: begin
                if (push_req) begin
                    // T_FILL_FIRST
                    state_nx = (DEPTH == 1) ? ST_FULL : ST_PARTIAL;
                    count_nx = CNT_ONE;
                end
            end
            ST_PARTIAL: begin
                if (push_req && !pop_req) begin
                    count_nx = count + 1'b1;
                    if (count == CNT_TOP) begin
                        state_nx = ST_FULL;     // T_TOP_OFF
                    end
                end else if (pop_req && !push_req) begin
                    count_nx = count - 1'b1;
                    if (count == CNT_ONE) begin
                        state_nx = ST_EMPTY;    // T_DRAIN_LAST
                    end
                end
                // push and pop together: T_EXCHANGE, no change
            end
            ST_FULL: begin
                if (pop_req) begin
                    // T_RELEASE
                    state_nx = (DEPTH == 1) ? ST_EMPTY : ST_PARTIAL;
                    count_nx = count - 1'b1;
                end
            end
            default: begin
                state_nx = ST_EMPTY;
                count_nx = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        push_ok  = 1'b0;
        pop_ok   = 1'b0;
        is_empty = 1'b0;
        is_full  = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                push_ok  = 1'b1;
                is_empty = 1'b1;
            end
            ST_PARTIAL: begin
                push_ok = 1'b1;
                pop_ok  = 1'b1;
            end
            ST_FULL: begin
                pop_ok  = 1'b1;
                is_full = 1'b1;
            end
            default: begin
                is_empty = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/resp_rd_window.sv
module resp_rd_window
    import dma_resp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [OFS_W-1:0]  rd_addr,
    input  resp_rec_t         head_rec,
    input  logic              have_rec,
    output logic              pop_req,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [WORD_W-1:0] sel_word;

    assign pop_req = rd_en && (rd_addr == OFS_STATUS);

    always_comb begin
        sel_word = '0;
        if (have_rec) begin
            unique case (rd_addr)
                OFS_BYTES:  sel_word = WORD_W'(head_rec.bytes);
                OFS_STATUS: sel_word = status_word(head_rec);
                default:    sel_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= sel_word;
            end
        end
    end

endmodule

// File: rtl/dma_resp_port.sv
module dma_resp_port
    import dma_resp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    output logic              push_ready,
    input  logic [BYTES_W-1:0] push_bytes,
    input  logic [ERR_W-1:0]  push_err,
    input  logic              push_early,
    input  logic              rd_en,
    input  logic [OFS_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [WORD_W-1:0] fill_word,
    output logic              empty_o,
    output logic              full_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    resp_rec_t        in_rec;
    resp_rec_t        head_rec;
    logic             push_ok;
    logic             pop_ok;
    logic             pop_req;
    logic             push_fire;
    logic             pop_fire;
    logic [CNT_W-1:0] count;
    logic [LVL_W-1:0] lvl;

    assign in_rec.early = push_early;
    assign in_rec.err   = push_err;
    assign in_rec.bytes = push_bytes;

    assign push_fire  = push_valid && push_ok;
    assign pop_fire   = pop_req && pop_ok;
    assign push_ready = push_ok;

    resp_occ_fsm #(.DEPTH(DEPTH)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_fire),
        .pop_req  (pop_fire),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .count    (count),
        .is_empty (empty_o),
        .is_full  (full_o)
    );

    resp_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (push_fire),
        .wr_rec   (in_rec),
        .rd_adv   (pop_fire),
        .head_rec (head_rec)
    );

    resp_rd_window u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .head_rec (head_rec),
        .have_rec (pop_ok),
        .pop_req  (pop_req),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign lvl       = LVL_W'(count);
    assign fill_word = WORD_W'(lvl);

endmodule

// File: rtl/resp_port_chk.sv
module resp_port_chk
    import dma_resp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_valid,
    input logic              push_ready,
    input logic              rd_en,
    input logic [OFS_W-1:0]  rd_addr,
    input logic [WORD_W-1:0] rd_data,
    input logic              rd_valid,
    input logic [WORD_W-1:0] fill_word,
    input logic              empty_o,
    input logic              full_o
);

    logic pushing;
    logic status_rd;
    assign pushing   = push_valid && push_ready;
    assign status_rd = rd_en && (rd_addr == OFS_STATUS);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_word <= WORD_W'(DEPTH));

    assert_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !push_ready);

    assert_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o == (fill_word == '0)) && (full_o == (fill_word == WORD_W'(DEPTH))));

    assert_peek_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == OFS_BYTES && !pushing) |=> $stable(fill_word));

    assert_rd_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_pop_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !empty_o && !pushing) |=> (fill_word == $past(fill_word) - 1));

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !pushing) |=> empty_o);

    assert_empty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty_o) |=> (rd_data == '0));

    assert_exchange_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !empty_o && pushing) |=> $stable(fill_word));

    assert_other_ofs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr != OFS_BYTES && rd_addr != OFS_STATUS) |=> (rd_data == '0));

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && status_rd) |=> push_ready);

endmodule

bind dma_resp_port resp_port_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .fill_word  (fill_word),
    .empty_o    (empty_o),
    .full_o     (full_o)
);

// File: tb/sim_dma_resp_port.sv
module sim_dma_resp_port;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic        push_ready;
    logic [31:0] push_bytes = '0;
    logic [7:0]  push_err = '0;
    logic        push_early = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [31:0] fill_word;
    logic        empty_o;
    logic        full_o;

    int checks = 0;
    int errors = 0;
    int seq    = 0;
    logic [40:0] mq[$];

    always #5 clk = ~clk;

    dma_resp_port #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_ready(push_ready),
        .push_bytes(push_bytes), .push_err(push_err), .push_early(push_early),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .fill_word(fill_word), .empty_o(empty_o), .full_o(full_o)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [40:0] mk_rec(input int n);
        logic [40:0] r;
        r[31:0]  = 32'h1000_0000 + 32'(n) * 32'd37;
        r[39:32] = 8'(n) ^ 8'h5a;
        r[40]    = n[0];
        return r;
    endfunction

    function automatic logic [31:0] stat_of(input logic [40:0] r);
        return {23'b0, r[40], r[39:32]};
    endfunction

    task automatic drive_rec(input logic [40:0] r);
        push_bytes = r[31:0];
        push_err   = r[39:32];
        push_early = r[40];
    endtask

    task automatic push_one();
        logic [40:0] r;
        r = mk_rec(seq);
        seq++;
        drive_rec(r);
        push_valid = 1'b1;
        step();
        push_valid = 1'b0;
        mq.push_back(r);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_en = 1'b1;
        rd_addr = a;
        step();
        rd_en = 1'b0;
        d = rd_data;
        chk(rd_valid == 1'b1, "R2 rd_valid", 32'(rd_valid), 32'd1);
    endtask

    // pop one record via peek and status, compare with model
    task automatic pop_check(input string req);
        logic [31:0] d;
        logic [40:0] e;
        int lvl;
        e = mq.pop_front();
        lvl = mq.size();
        rd(3'h0, d);
        chk(d == e[31:0], {req, " bytes word"}, d, e[31:0]);
        rd(3'h4, d);
        chk(d == stat_of(e), {req, " status word"}, d, stat_of(e));
        chk(fill_word == 32'(lvl), {req, " level after pop"}, fill_word, 32'(lvl));
    endtask

    task automatic t_reset();
        chk(empty_o == 1'b1, "R1 empty", 32'(empty_o), 32'd1);
        chk(full_o == 1'b0, "R1 full", 32'(full_o), 32'd0);
        chk(fill_word == 32'd0, "R1 level", fill_word, 32'd0);
        chk(push_ready == 1'b1, "R1 ready", 32'(push_ready), 32'd1);
        chk(rd_valid == 1'b0, "R1 rd_valid", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_peek_pop();
        logic [31:0] d;
        for (int i = 0; i < 3; i++) push_one();
        chk(fill_word == 32'd3, "R7 level three", fill_word, 32'd3);
        chk(empty_o == 1'b0, "R7 not empty", 32'(empty_o), 32'd0);
        rd(3'h0, d);
        chk(d == mq[0][31:0], "R2 peek first", d, mq[0][31:0]);
        rd(3'h0, d);
        chk(d == mq[0][31:0], "R2 peek again", d, mq[0][31:0]);
        chk(fill_word == 32'd3, "R2 level kept", fill_word, 32'd3);
        rd(3'h4, d);
        chk(d == stat_of(mq[0]), "R3 status", d, stat_of(mq[0]));
        chk(fill_word == 32'd2, "R3 level dec", fill_word, 32'd2);
        void'(mq.pop_front());
        while (mq.size() > 0) pop_check("R4");
        chk(empty_o == 1'b1, "R7 empty again", 32'(empty_o), 32'd1);
    endtask

    task automatic t_wrap();
        for (int b = 0; b < 10; b++) begin
            for (int i = 0; i < 5; i++) push_one();
            for (int i = 0; i < 5; i++) pop_check("R4 wrap");
        end
    endtask

    task automatic t_empty_read();
        logic [31:0] d;
        rd(3'h4, d);
        chk(d == 32'd0, "R5 empty status zero", d, 32'd0);
        rd(3'h0, d);
        chk(d == 32'd0, "R5 empty bytes zero", d, 32'd0);
        chk(fill_word == 32'd0, "R5 no underflow", fill_word, 32'd0);
        push_one();
        chk(fill_word == 32'd1, "R5 push after empty read", fill_word, 32'd1);
        pop_check("R5");
    endtask

    task automatic t_other_ofs();
        logic [31:0] d;
        push_one();
        for (int a = 0; a < 8; a++) begin
            if (a != 0 && a != 4) begin
                rd(3'(a), d);
                chk(d == 32'd0, "R9 other offset zero", d, 32'd0);
                chk(fill_word == 32'd1, "R9 no pop", fill_word, 32'd1);
            end
        end
        pop_check("R9");
    endtask

    task automatic t_full();
        logic [40:0] x;
        logic [31:0] d;
        logic [40:0] h;
        for (int i = 0; i < DEPTH; i++) push_one();
        chk(full_o == 1'b1, "R6 full flag", 32'(full_o), 32'd1);
        chk(push_ready == 1'b0, "R6 ready low", 32'(push_ready), 32'd0);
        chk(fill_word[15:0] == 16'(DEPTH) && fill_word[31:16] == 16'd0,
            "R7 level full", fill_word, 32'(DEPTH));
        x = mk_rec(seq);
        seq++;
        drive_rec(x);
        push_valid = 1'b1;
        step(); step(); step();
        chk(fill_word == 32'(DEPTH), "R6 held push not taken", fill_word, 32'(DEPTH));
        h = mq.pop_front();
        rd_en = 1'b1;
        rd_addr = 3'h4;
        step();
        rd_en = 1'b0;
        chk(rd_data == stat_of(h), "R10 status while full", rd_data, stat_of(h));
        chk(push_ready == 1'b1, "R10 ready after release", 32'(push_ready), 32'd1);
        chk(fill_word == 32'(DEPTH - 1), "R10 level after release", fill_word, 32'(DEPTH - 1));
        step();
        push_valid = 1'b0;
        mq.push_back(x);
        chk(fill_word == 32'(DEPTH), "R6 held push taken", fill_word, 32'(DEPTH));
        while (mq.size() > 0) pop_check("R6 drain");
        rd(3'h0, d);
        chk(d == 32'd0, "R5 drained read zero", d, 32'd0);
    endtask

    task automatic t_collide();
        logic [40:0] r;
        logic [40:0] h;
        push_one();
        push_one();
        r = mk_rec(seq);
        seq++;
        drive_rec(r);
        h = mq.pop_front();
        push_valid = 1'b1;
        rd_en = 1'b1;
        rd_addr = 3'h4;
        step();
        push_valid = 1'b0;
        rd_en = 1'b0;
        mq.push_back(r);
        chk(rd_data == stat_of(h), "R8 old head returned", rd_data, stat_of(h));
        chk(fill_word == 32'd2, "R8 level unchanged", fill_word, 32'd2);
        while (mq.size() > 0) pop_check("R8 order");
        r = mk_rec(seq);
        seq++;
        drive_rec(r);
        push_valid = 1'b1;
        rd_en = 1'b1;
        rd_addr = 3'h4;
        step();
        push_valid = 1'b0;
        rd_en = 1'b0;
        mq.push_back(r);
        chk(rd_data == 32'd0, "R8 empty collide reads zero", rd_data, 32'd0);
        chk(fill_word == 32'd1, "R8 empty collide keeps push", fill_word, 32'd1);
        pop_check("R8 empty collide");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_peek_pop();
        t_wrap();
        t_empty_read();
        t_other_ofs();
        t_full();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule